// File: doc/BRIEF.md
# Stop-Mode Clock and Wake Controller

This block governs a low-power stop state for a small processor. When software pulses the stop request while the CPU is running, the controller halts execution. It also powers down both the crystal oscillator and the internal RC oscillator, and it marks the stop state as active. Only two events end the stop state. One is an external interrupt line whose enable bit is set. The other is the external reset. Interrupt lines are level inputs. A free-running wake path masks them with their enables, ORs them together and passes the result through a synchronizer before the state machine acts on it.

On wake, a policy input picks one of two behaviours. In the hold policy, the CPU stays stalled on the crystal until a warm-up period has run out and the crystal reports ready. In the RC policy, the CPU resumes at once on the RC oscillator and moves over to the crystal when the same warm-up and ready condition is met. The warm-up length is a parameter counted in clock cycles. The stop indication clears by itself on wake. After reset, the controller follows the hold policy from the crystal.

Top module: `stopwake_ctrl`

## Requirements
- R1: While reset is low, and for WARM_CYCLES+2 rising edges after its release, the outputs read xtal_en=1, rc_en=1, clk_sel=1 (crystal), cpu_run=0 and stop_flag=0. On the next edge, with xtal_ready high, the outputs read cpu_run=1, clk_sel=1 and rc_en=0.
- R2: A stop_set pulse sampled while cpu_run=1 gives stop_flag=1, cpu_run=0, xtal_en=0, rc_en=0 and clk_sel=0 after that edge.
- R3: While stopped, interrupt lines whose wake_en bit is 0 have no effect, and the block stays stopped.
- R4: An interrupt line that is high with its wake_en bit set, applied while stopped, leaves stop_flag at 1 for two rising edges. stop_flag falls on the third edge.
- R5: With wake_mode=0 (hold), the wake edge enters a state with cpu_run=0, clk_sel=1, xtal_en=1 and rc_en=1.
- R6: With wake_mode=1 (RC), the wake edge enters a state with cpu_run=1, clk_sel=0 (RC), xtal_en=1 and rc_en=1.
- R7: After a wake, the block moves to the run state (cpu_run=1, clk_sel=1, rc_en=0) on rising edge max(WARM_CYCLES, D)+1 counted from the wake edge. D is the number of edges before xtal_ready rises. It never switches while xtal_ready is low.
- R8: stop_set is ignored while cpu_run=0 during warm-up.
- R9: Asserting reset while stopped leaves the stop state at once, without a clock edge, and gives the R1 reset outputs.
- R10: stop_set while running on the RC oscillator after a wake enters the stop state as in R2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock of the controller |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| stop_set | input | 1 | One-cycle software request to enter stop |
| wake_mode | input | 1 | Wake policy: 0 hold for crystal, 1 resume on RC |
| wake_irq | input | NUM_WAKE | External interrupt levels |
| wake_en | input | NUM_WAKE | Per-line wake enables |
| xtal_ready | input | 1 | Crystal reports stable oscillation |
| xtal_en | output | 1 | Crystal oscillator enable |
| rc_en | output | 1 | RC oscillator enable |
| clk_sel | output | 1 | System clock source: 1 crystal, 0 RC |
| cpu_run | output | 1 | CPU clock gate enable |
| stop_flag | output | 1 | Stop bit, cleared automatically on wake |

## Verification
The properties assume that stop_set is a single-cycle pulse. They also assume that an enabled interrupt stays high for at least the synchronizer depth, because shorter pulses can be lost in the wake path. They treat xtal_ready as meaningful only while the crystal is enabled. The bench drives every input at falling edges. It lowers xtal_ready on each stop entry and raises it again after a random delay, and it holds the chosen enabled line high until the stop state has been left. Random enable masks are never zero on a waking pass, and the lines driven before the wake are always masked off.

// File: rtl/stopwake_pkg.sv
package stopwake_pkg;
  typedef enum logic [1:0] {
    SW_RUN   = 2'd0,
    SW_STOP  = 2'd1,
    SW_WARM  = 2'd2,
    SW_RCRUN = 2'd3
  } sw_state_e;

  localparam logic CLKSEL_RC   = 1'b0;
  localparam logic CLKSEL_XTAL = 1'b1;
  localparam logic POLICY_HOLD = 1'b0;
  localparam logic POLICY_RC   = 1'b1;
endpackage

// File: rtl/stopwake_sync.sv
module stopwake_sync #(
  parameter int WIDTH  = 1,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             arst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  generate
    if (STAGES == 1) begin : g_single
      logic [WIDTH-1:0] stage_q;
      always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) stage_q <= '0;
        else         stage_q <= d;
      end
      assign q = stage_q;
    end else begin : g_chain
      logic [STAGES-1:0][WIDTH-1:0] chain_q;
      always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) chain_q <= '0;
        else         chain_q <= {chain_q[STAGES-2:0], d};
      end
      assign q = chain_q[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/stopwake_warm_cnt.sv
module stopwake_warm_cnt #(
  parameter int WARM_CYCLES = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic run,
  output logic done
);
  localparam int CW = $clog2(WARM_CYCLES + 1);
  localparam logic [CW-1:0] LIMIT = CW'(WARM_CYCLES);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (clear)                    cnt_d = '0;
    else if (run && cnt_q != LIMIT) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign done = (cnt_q == LIMIT);
endmodule

// File: rtl/stopwake_ctrl.sv
module stopwake_ctrl
  import stopwake_pkg::*;
#(
  parameter int NUM_WAKE    = 8,
  parameter int WARM_CYCLES = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                stop_set,
  input  logic                wake_mode,
  input  logic [NUM_WAKE-1:0] wake_irq,
  input  logic [NUM_WAKE-1:0] wake_en,
  input  logic                xtal_ready,
  output logic                xtal_en,
  output logic                rc_en,
  output logic                clk_sel,
  output logic                cpu_run,
  output logic                stop_flag
);
  logic      rst_sync_n;
  logic      wake_req;
  logic      wake_sync;
  logic      warm_done;
  logic      warm_clear;
  logic      warm_run;
  sw_state_e state_q, state_d;

  // reset: asserts at once, releases on the clock
  stopwake_sync #(.WIDTH(1), .STAGES(2)) u_rst_sync (
    .clk    (clk),
    .arst_n (rst_n),
    .d      (1'b1),
    .q      (rst_sync_n)
  );

  // free wake path: masked levels, ORed, then synchronized
  assign wake_req = |(wake_irq & wake_en);

  stopwake_sync #(.WIDTH(1), .STAGES(SYNC_STAGES)) u_wake_sync (
    .clk    (clk),
    .arst_n (rst_sync_n),
    .d      (wake_req),
    .q      (wake_sync)
  );

  assign warm_clear = (state_q == SW_STOP);
  assign warm_run   = (state_q == SW_WARM) || (state_q == SW_RCRUN);

  stopwake_warm_cnt #(.WARM_CYCLES(WARM_CYCLES)) u_warm (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .clear (warm_clear),
    .run   (warm_run),
    .done  (warm_done)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      SW_RUN:   if (stop_set) state_d = SW_STOP;
      SW_RCRUN: begin
        if (stop_set)                    state_d = SW_STOP;
        else if (warm_done && xtal_ready) state_d = SW_RUN;
      end
      SW_WARM:  if (warm_done && xtal_ready) state_d = SW_RUN;
      SW_STOP:  if (wake_sync)
                  state_d = (wake_mode == POLICY_RC) ? SW_RCRUN : SW_WARM;
      default:  state_d = SW_WARM;
    endcase
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) state_q <= SW_WARM;
    else             state_q <= state_d;
  end

  always_comb begin
    xtal_en   = 1'b1;
    rc_en     = 1'b1;
    clk_sel   = CLKSEL_XTAL;
    cpu_run   = 1'b0;
    stop_flag = 1'b0;
    unique case (state_q)
      SW_RUN: begin
        rc_en   = 1'b0;
        cpu_run = 1'b1;
      end
      SW_STOP: begin
        xtal_en   = 1'b0;
        rc_en     = 1'b0;
        clk_sel   = CLKSEL_RC;
        stop_flag = 1'b1;
      end
      SW_RCRUN: begin
        clk_sel = CLKSEL_RC;
        cpu_run = 1'b1;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/stopwake_ctrl_chk.sv
module stopwake_ctrl_chk (
  input logic clk,
  input logic rst_n,
  input logic stop_set,
  input logic wake_s,
  input logic xtal_ready,
  input logic xtal_en,
  input logic rc_en,
  input logic clk_sel,
  input logic cpu_run,
  input logic stop_flag
);
  a_r2_stop_entry: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_run && stop_set |=> stop_flag && !cpu_run && !xtal_en && !rc_en);

  a_r3_hold_stop: assert property (@(posedge clk) disable iff (!rst_n)
    stop_flag && !wake_s |=> stop_flag);

  a_r4_wake_exit: assert property (@(posedge clk) disable iff (!rst_n)
    stop_flag && wake_s |=> !stop_flag);

  a_r7_xtal_switch: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(clk_sel) && cpu_run |-> $past(xtal_ready));

  a_r8_no_stop_halted: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_run && !stop_flag |=> !stop_flag);
endmodule

bind stopwake_ctrl stopwake_ctrl_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_sync_n),
  .stop_set   (stop_set),
  .wake_s     (wake_sync),
  .xtal_ready (xtal_ready),
  .xtal_en    (xtal_en),
  .rc_en      (rc_en),
  .clk_sel    (clk_sel),
  .cpu_run    (cpu_run),
  .stop_flag  (stop_flag)
);

// File: tb/stopwake_ctrl_bench.sv
module stopwake_ctrl_bench;
  localparam int NW = 8;
  localparam int W  = 16;
  localparam int P_RUN = 0, P_STOP = 1, P_WARM = 2, P_RC = 3;

  logic clk = 1'b0;
  logic rst_n, stop_set, wake_mode, xtal_ready;
  logic [NW-1:0] wake_irq, wake_en;
  logic xtal_en, rc_en, clk_sel, cpu_run, stop_flag;
  int checks = 0;
  int errors = 0;
  int seed_val;

  always #10 clk = ~clk;

  stopwake_ctrl #(.NUM_WAKE(NW), .WARM_CYCLES(W), .SYNC_STAGES(2)) u_stopwake_ctrl (
    .clk(clk), .rst_n(rst_n), .stop_set(stop_set), .wake_mode(wake_mode),
    .wake_irq(wake_irq), .wake_en(wake_en), .xtal_ready(xtal_ready),
    .xtal_en(xtal_en), .rc_en(rc_en), .clk_sel(clk_sel), .cpu_run(cpu_run),
    .stop_flag(stop_flag)
  );

  // {xtal_en, rc_en, clk_sel, cpu_run, stop_flag}
  function automatic logic [4:0] exp_vec(int ph);
    case (ph)
      P_RUN:   return 5'b10110;
      P_STOP:  return 5'b00001;
      P_WARM:  return 5'b11100;
      default: return 5'b11010;
    endcase
  endfunction

  task automatic check_phase(string tag, int ph);
    logic [4:0] act;
    act = {xtal_en, rc_en, clk_sel, cpu_run, stop_flag};
    checks++;
    if (act !== exp_vec(ph)) begin
      errors++;
      $display("FAIL %s: outputs %b expected %b (t=%0t)", tag, act, exp_vec(ph), $time);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic enter_stop(string tag);
    stop_set = 1'b1;
    tick(1);
    stop_set = 1'b0;
    xtal_ready = 1'b0;
    check_phase(tag, P_STOP);
  endtask

  // wake through line bit_i, crystal ready after d edges
  task automatic wake_seq(logic mode, logic [NW-1:0] en, int bit_i, int d);
    int t;
    wake_mode = mode;
    wake_en = en;
    wake_irq = NW'($urandom) & ~en;
    tick(5);
    check_phase("R3", P_STOP);
    wake_irq = '0;
    wake_irq[bit_i] = 1'b1;
    tick(2);
    check_phase("R4", P_STOP);
    tick(1);
    wake_irq = '0;
    t = ((d > W) ? d : W) + 1;
    for (int k = 0; k < t; k++) begin
      if (k == d) xtal_ready = 1'b1;
      stop_set = (mode == 1'b0 && k == 1);
      if (k == 0)                     check_phase("R4", mode ? P_RC : P_WARM);
      else if (k == 2 && mode == 1'b0) check_phase("R8", P_WARM);
      else if (k > W)                 check_phase("R7", mode ? P_RC : P_WARM);
      else                            check_phase(mode ? "R6" : "R5", mode ? P_RC : P_WARM);
      tick(1);
    end
    stop_set = 1'b0;
    check_phase("R7", P_RUN);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not finish, actual hung expected done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    seed_val = $urandom(32'd4711);
    rst_n = 1'b0; stop_set = 1'b0; wake_mode = 1'b0; xtal_ready = 1'b1;
    wake_irq = '0; wake_en = '0;
    tick(3);
    check_phase("R1", P_WARM);
    rst_n = 1'b1;
    tick(2 + W);
    check_phase("R1", P_WARM);
    tick(1);
    check_phase("R1", P_RUN);

    // all lines high, none enabled: stays stopped
    enter_stop("R2");
    wake_en = '0; wake_irq = '1;
    tick(10);
    check_phase("R3", P_STOP);
    wake_irq = '0;
    wake_seq(1'b0, 8'h01, 0, 3);

    // crystal late, beyond warm-up
    enter_stop("R2");
    wake_seq(1'b0, 8'h80, 7, W + 20);
    enter_stop("R2");
    wake_seq(1'b1, 8'h10, 4, W + 12);

    // stop while running on RC
    enter_stop("R2");
    wake_mode = 1'b1; wake_en = 8'h04; wake_irq = 8'h04;
    tick(3);
    wake_irq = '0;
    check_phase("R6", P_RC);
    tick(2);
    enter_stop("R10");
    wake_seq(1'b0, 8'h04, 2, 0);

    // constrained random passes
    for (int it = 0; it < 40; it++) begin
      logic [NW-1:0] en;
      int b;
      en = NW'($urandom);
      if (en == '0) en = 8'h20;
      b = $urandom % NW;
      while (!en[b]) b = (b + 1) % NW;
      enter_stop("R2");
      wake_seq(1'($urandom), en, b, $urandom % (W + 8));
    end

    // reset while stopped
    enter_stop("R2");
    #5 rst_n = 1'b0;
    #1 check_phase("R9", P_WARM);
    xtal_ready = 1'b1;
    @(negedge clk);
    rst_n = 1'b1;
    tick(2 + W);
    check_phase("R1", P_WARM);
    tick(1);
    check_phase("R1", P_RUN);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule